// File: doc/BRIEF.md
# Dual-mode parallel port with strobe capture

An eight-bit pin controller that serves one of two roles, chosen by a mode bit in its control register. In single-chip mode the pins are general-purpose I/O. Each pin has a direction bit and an output value bit. A global open-drain bit turns every driven pin into a wired-OR output. An edge on the strobe input captures the pin inputs into a latched-input register, which is separate from the output data register. Each capture sets a sticky flag and pulses the handshake output.

In expanded mode the same pins carry a multiplexed bus. While the bus-phase signal is low they drive the low address byte. While it is high they carry data. On a write cycle the pins drive the internal write data. On a read cycle the pins release, and the value on them is registered onto the internal read-data bus. In this mode the data, direction and open-drain settings do not affect the pins, but those registers can still be read and written.

Register map (3-bit address): 0 = output data, 1 = direction (1 = output), 2 = control, 3 = latched input, 4 = live synchronized pins. Control bits: bit 0 = open-drain, bit 1 = capture on falling strobe edge, bit 2 = expanded mode, bit 7 = capture flag (read-only). Register reads are registered and appear on the data output one clock after the read request. All outputs are registered.

Top module: `pio_mux_port`

## Requirements
- R1: After reset, pin_oe, hs_out and reg_rdata are 0. Every register reads 0, and the mode is single-chip.
- R2: In single-chip mode with control bit 0 clear, pin_oe equals the direction register and pin_o equals the data register. The pins update one clock after the register write.
- R3: In single-chip mode with control bit 0 set, a pin is enabled only where its direction bit is 1 and its data bit is 0. The pin never drives a 1.
- R4: With control bit 1 clear, a rising strobe edge loads the synchronized pin inputs into register 3. The data register is not affected.
- R5: With control bit 1 set, a falling strobe edge captures the pins, and a rising edge captures nothing.
- R6: Each capture sets control bit 7. A read of register 3 clears it. Writes to bit 7 have no effect.
- R7: hs_out is high for exactly one clock per capture.
- R8: In expanded mode with bus_e low, every pin is enabled and pin_o equals addr_lo.
- R9: In expanded mode with bus_e high and bus_rw 0 (write), every pin is enabled and pin_o equals bus_wdata.
- R10: In expanded mode with bus_e high and bus_rw 1 (read), no pin is enabled. bus_rdata takes pin_i one clock later.
- R11: In expanded mode the open-drain, direction and data settings do not affect the pins, and the data register stays readable and writable.
- R12: A read of register 4 returns pin_i as seen through the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| strobe_in | input | 1 | Capture strobe, asynchronous |
| hs_out | output | 1 | One-clock pulse per capture |
| bus_e | input | 1 | Bus phase: 0 = address, 1 = data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| addr_lo | input | 8 | Low address byte |
| bus_wdata | input | 8 | Internal write data |
| bus_rdata | output | 8 | Data captured from pins on bus reads |
| pin_o | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pin_i | input | 8 | Pin input values |

## Verification
The bench builds the port with its default width of eight and two synchronizer stages. This makes the fixed three-clock delay from strobe edge to capture exact and predictable, and it places the flag at bit 7. A vector table covers push-pull, open-drain and all three expanded bus phases, including one vector where open-drain and direction settings must be ignored. Directed tests follow for both strobe polarities, flag clearing, the live pin read and register access while in expanded mode.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    A_DATA  = 3'd0,
    A_DIR   = 3'd1,
    A_CTRL  = 3'd2,
    A_LATCH = 3'd3,
    A_PINS  = 3'd4
  } reg_addr_e;

  localparam int CB_OD  = 0;
  localparam int CB_NEG = 1;
  localparam int CB_EXP = 2;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pio_strobe_cap.sv
module pio_strobe_cap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_s,
  input  logic         neg_sel,
  input  logic [W-1:0] pins_s,
  input  logic         clr,
  output logic [W-1:0] latch_q,
  output logic         flag_q,
  output logic         hs_out
);
  logic prev;
  logic cap;

  assign cap = neg_sel ? (prev & ~strobe_s) : (strobe_s & ~prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      latch_q <= '0;
      flag_q  <= 1'b0;
      hs_out  <= 1'b0;
    end else begin
      prev   <= strobe_s;
      hs_out <= cap;
      if (cap) begin
        latch_q <= pins_s;
        flag_q  <= 1'b1;
      end else if (clr) begin
        flag_q  <= 1'b0;
      end
    end
  end

  assert_hs_single_R7: assert property (@(posedge clk) disable iff (rst)
    hs_out |=> !hs_out);
  assert_flag_on_capture_R6: assert property (@(posedge clk) disable iff (rst)
    hs_out |-> flag_q);
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  latch_q,
  input  logic          flag_q,
  input  logic [W-1:0]  pins_s,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q,
  output logic          od,
  output logic          neg,
  output logic          exp,
  output logic          clr_latch,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ctrl_view;

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[CB_OD]  = od;
    ctrl_view[CB_NEG] = neg;
    ctrl_view[CB_EXP] = exp;
    ctrl_view[W-1]    = flag_q;
  end

  assign clr_latch = re && (addr == A_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      od     <= 1'b0;
      neg    <= 1'b0;
      exp    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_DATA: data_q <= wdata;
          A_DIR:  dir_q  <= wdata;
          A_CTRL: begin
            od  <= wdata[CB_OD];
            neg <= wdata[CB_NEG];
            exp <= wdata[CB_EXP];
          end
          default: ;
        endcase
      end
      if (re) begin
        case (addr)
          A_DATA:  rdata <= data_q;
          A_DIR:   rdata <= dir_q;
          A_CTRL:  rdata <= ctrl_view;
          A_LATCH: rdata <= latch_q;
          A_PINS:  rdata <= pins_s;
          default: rdata <= '0;
        endcase
      end
    end
  end

  assert_reset_rdata_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata == '0));
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exp,
  input  logic         od,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  input  logic         bus_e,
  input  logic         bus_rw,
  input  logic [W-1:0] addr_lo,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o     <= '0;
      pin_oe    <= '0;
      bus_rdata <= '0;
    end else if (exp) begin
      if (!bus_e) begin
        pin_o  <= addr_lo;
        pin_oe <= '1;
      end else if (!bus_rw) begin
        pin_o  <= bus_wdata;
        pin_oe <= '1;
      end else begin
        pin_oe    <= '0;
        bus_rdata <= pin_i;
      end
    end else begin
      pin_o  <= data_q;
      pin_oe <= od ? (dir_q & ~data_q) : dir_q;
    end
  end

  assert_od_no_high_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!exp && od) |-> ((pin_oe & pin_o) == '0));
  assert_read_float_R10: assert property (@(posedge clk) disable iff (rst)
    $past(exp && bus_e && bus_rw) |-> (pin_oe == '0));
endmodule

// File: rtl/pio_mux_port.sv
module pio_mux_port #(
  parameter int W           = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          strobe_in,
  output logic          hs_out,
  input  logic          bus_e,
  input  logic          bus_rw,
  input  logic [W-1:0]  addr_lo,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe,
  input  logic [W-1:0]  pin_i
);
  logic         strobe_s;
  logic [W-1:0] pins_s;
  logic [W-1:0] latch_q;
  logic         flag_q;
  logic         clr_latch;
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic         od, neg, exp;

  pio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_stb (
    .clk(clk), .rst(rst), .d(strobe_in), .q(strobe_s)
  );

  pio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync_pin (
    .clk(clk), .rst(rst), .d(pin_i), .q(pins_s)
  );

  pio_strobe_cap #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .strobe_s(strobe_s), .neg_sel(neg),
    .pins_s(pins_s), .clr(clr_latch), .latch_q(latch_q),
    .flag_q(flag_q), .hs_out(hs_out)
  );

  pio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .latch_q(latch_q), .flag_q(flag_q),
    .pins_s(pins_s), .data_q(data_q), .dir_q(dir_q), .od(od),
    .neg(neg), .exp(exp), .clr_latch(clr_latch), .rdata(reg_rdata)
  );

  pio_pin_mux #(.W(W)) u_mux (
    .clk(clk), .rst(rst), .exp(exp), .od(od), .dir_q(dir_q),
    .data_q(data_q), .bus_e(bus_e), .bus_rw(bus_rw), .addr_lo(addr_lo),
    .bus_wdata(bus_wdata), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/tb_pio_mux_port.sv
module tb_pio_mux_port;
  logic       clk = 0;
  logic       rst = 1;
  logic       reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       strobe_in = 0;
  logic       hs_out;
  logic       bus_e = 0, bus_rw = 0;
  logic [7:0] addr_lo = 0, bus_wdata = 0, bus_rdata;
  logic [7:0] pin_o, pin_oe, pin_i = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pio_mux_port dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .strobe_in(strobe_in), .hs_out(hs_out), .bus_e(bus_e), .bus_rw(bus_rw),
    .addr_lo(addr_lo), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_o(pin_o), .pin_oe(pin_oe), .pin_i(pin_i)
  );

  typedef struct packed {
    logic [7:0] ctrl, dir, data;
    logic       e, rw;
    logic [7:0] addr, wd, eo, eoe;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{8'h00, 8'hF0, 8'hA5, 1'b0, 1'b0, 8'h00, 8'h00, 8'hA0, 8'hF0}, // R2
    '{8'h01, 8'hFF, 8'hA5, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h5A}, // R3
    '{8'h01, 8'h0F, 8'h33, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h0C}, // R3
    '{8'h04, 8'h00, 8'h00, 1'b0, 1'b0, 8'h3C, 8'h00, 8'h3C, 8'hFF}, // R8
    '{8'h05, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h00, 8'h96, 8'h96, 8'hFF}, // R9
    '{8'h04, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00}, // R10
    '{8'h05, 8'h00, 8'h00, 1'b0, 1'b0, 8'hC3, 8'h00, 8'hC3, 8'hFF}  // R11
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic strobe_to(input logic lvl, output int hs_cnt);
    @(negedge clk);
    strobe_in = lvl;
    hs_cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      if (hs_out) hs_cnt++;
    end
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int hc;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 hs", {7'd0, hs_out}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    rd(3'd2, v); check("R1 ctrl", v, 8'h00);
    rd(3'd0, v); check("R1 data", v, 8'h00);
    rd(3'd3, v); check("R1 latch", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(3'd2, VT[i].ctrl);
      wr(3'd1, VT[i].dir);
      wr(3'd0, VT[i].data);
      @(negedge clk);
      bus_e = VT[i].e; bus_rw = VT[i].rw;
      addr_lo = VT[i].addr; bus_wdata = VT[i].wd;
      @(posedge clk); @(posedge clk); #1;
      check($sformatf("vec%0d oe R2/R3/R8-R11", i), pin_oe, VT[i].eoe);
      check($sformatf("vec%0d o R2/R3/R8-R11", i), pin_o & pin_oe, VT[i].eo);
    end

    // R10 bus read capture
    wr(3'd2, 8'h04);
    @(negedge clk); bus_e = 1; bus_rw = 1; pin_i = 8'hA7;
    @(posedge clk); #1;
    check("R10 bus_rdata", bus_rdata, 8'hA7);
    check("R10 oe", pin_oe, 8'h00);

    // R11 registers writable in expanded mode, pins follow address
    wr(3'd0, 8'h81);
    rd(3'd0, v); check("R11 data rw", v, 8'h81);
    @(negedge clk); bus_e = 0; addr_lo = 8'h55;
    @(posedge clk); @(posedge clk); #1;
    check("R11 pins addr", pin_o, 8'h55);

    // back to single-chip; data 81 still held
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);
    // R4 rising capture
    @(negedge clk); pin_i = 8'h5A;
    repeat (4) @(posedge clk);
    strobe_to(1'b1, hc);
    check("R7 hs rising", hc[7:0], 8'd1);
    rd(3'd2, v); check("R6 flag set", v & 8'h80, 8'h80);
    rd(3'd3, v); check("R4 latch", v, 8'h5A);
    rd(3'd0, v); check("R4 data untouched", v, 8'h81);
    rd(3'd2, v); check("R6 flag cleared", v & 8'h80, 8'h00);
    wr(3'd2, 8'h80);
    rd(3'd2, v); check("R6 flag not writable", v, 8'h00);

    // R5 falling polarity
    wr(3'd2, 8'h02);
    @(negedge clk); pin_i = 8'h3C;
    repeat (4) @(posedge clk);
    strobe_to(1'b0, hc);
    check("R5 hs falling", hc[7:0], 8'd1);
    rd(3'd3, v); check("R5 latch falling", v, 8'h3C);
    @(negedge clk); pin_i = 8'hC3;
    repeat (4) @(posedge clk);
    strobe_to(1'b1, hc);
    check("R5 no hs on rising", hc[7:0], 8'd0);
    rd(3'd3, v); check("R5 latch kept", v, 8'h3C);
    rd(3'd2, v); check("R5 no flag", v, 8'h02);

    // R12 live pins
    @(negedge clk); pin_i = 8'h69;
    repeat (3) @(posedge clk);
    rd(3'd4, v); check("R12 live pins", v, 8'h69);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule